// File: doc/BRIEF.md
# Automatic acknowledgment timing sequencer

This block sits on the receive side of a 2.4 GHz packet radio link layer and decides when an acknowledgment frame goes out. While it listens it waits for a start-of-frame-delimiter detect. After the detect it holds a busy-receive state until the frame-end pulse arrives. At that pulse it raises a receive-end interrupt and looks at the frame type and the ACK-request flag. If the frame needs an acknowledgment, the block schedules the start of the ACK transmission.

The ACK start is timed in symbol periods, measured from the last received symbol. A symbol is counted as 16 ticks of an external 1 µs enable. With the fast-turnaround bit clear the ACK starts after 12 symbols (192 µs). With the bit set it starts after 2 symbols. In slotted operation the timer does not start the ACK: a rising edge on an external trigger pin starts it instead. When the transmitter reports that the ACK has gone out, the block raises a transmit-end interrupt and returns to listening. The frame type decoding, the ACK frame contents, CRC checking and the modulation are handled elsewhere.

Top module: `ack_turnaround_seq`

## Requirements
- R1: A synchronous active-high reset sets the state code to 0 (listening) and holds `rx_end_irq`, `tx_start` and `tx_end_irq` low. After reset the fast-turnaround setting is taken as clear.
- R2: In state 0, `sfd_det` moves the state code to 1 (busy receive) on the next cycle.
- R3: In state 1, `frame_end` produces a single-cycle `rx_end_irq` pulse on the next cycle.
- R4: At `frame_end` the block goes to state 2 (ACK wait) only when `ack_req` is high and `frame_type` is 1 (data) or 3 (MAC command). In every other case it goes to state 0.
- R5: With `fast_ack` low at `frame_end` and slotted mode off, `tx_start` rises directly after the edge that samples the 192nd `us_tick` counted after the `frame_end` edge.
- R6: With `fast_ack` high at `frame_end` and slotted mode off, `tx_start` rises directly after the edge that samples the 32nd such `us_tick`.
- R7: `tx_start` is a single-cycle pulse, and the state code is 3 (ACK transmit) from that cycle on.
- R8: With `slotted_en` high at `frame_end`, the symbol timer never starts the ACK. The first rising edge of `slot_trig` sampled after the `frame_end` cycle raises `tx_start` on the next cycle.
- R9: A `slot_trig` rising edge during busy receive, or in the same cycle as `frame_end`, has no effect.
- R10: In state 3, `tx_done` produces a single-cycle `tx_end_irq` on the next cycle and returns the state code to 0.
- R11: `sfd_det` has no effect in states 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | 1 µs enable, high for one cycle |
| sfd_det | input | 1 | Start-of-frame-delimiter detect pulse |
| frame_end | input | 1 | Last-symbol-received pulse |
| frame_type | input | 3 | Frame type code of the received frame |
| ack_req | input | 1 | ACK-request flag of the received frame |
| fast_ack | input | 1 | Selects the 2-symbol turnaround |
| slotted_en | input | 1 | Slotted mode: the trigger pin starts the ACK |
| slot_trig | input | 1 | External ACK trigger pin |
| tx_done | input | 1 | ACK transmission finished |
| state_o | output | 2 | State code: 0 listen, 1 busy, 2 wait, 3 transmit |
| rx_end_irq | output | 1 | Receive-end interrupt pulse |
| tx_start | output | 1 | ACK transmit-start strobe |
| tx_end_irq | output | 1 | Transmit-end interrupt pulse |

## Verification
The slotted trigger and the end of a frame can land in the same cycle. The block must then treat the trigger as early, because it has not yet seen the frame end. The bench raises `slot_trig` in the very cycle that `frame_end` is driven and holds the pin high afterwards. It then checks that the state stays at 2 and that no `tx_start` appears. Only after the pin is released and raised again does the scoreboard accept a `tx_start`. In timed mode the scoreboard compares the number of ticks counted at the strobe against 16 times the selected symbol count, with the tick enable running both every cycle and every third cycle.

// File: rtl/ack_turnaround_seq.sv
`timescale 1ns/1ps
module ack_turnaround_seq #(
  parameter int TICKS_PER_SYM = 16,
  parameter int SLOW_SYMS     = 12,
  parameter int FAST_SYMS     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       us_tick,
  input  logic       sfd_det,
  input  logic       frame_end,
  input  logic [2:0] frame_type,
  input  logic       ack_req,
  input  logic       fast_ack,
  input  logic       slotted_en,
  input  logic       slot_trig,
  input  logic       tx_done,
  output logic [1:0] state_o,
  output logic       rx_end_irq,
  output logic       tx_start,
  output logic       tx_end_irq
);
  localparam int MAXS = (SLOW_SYMS > FAST_SYMS) ? SLOW_SYMS : FAST_SYMS;
  localparam int TW   = $clog2(TICKS_PER_SYM);
  localparam int SW   = $clog2(MAXS + 1);

  typedef enum logic [1:0] {ST_LISTEN = 2'd0, ST_BUSY = 2'd1, ST_WAIT = 2'd2, ST_TX = 2'd3} st_t;

  st_t           st;
  logic [TW-1:0] tick_cnt;
  logic [SW-1:0] sym_cnt;
  logic          fast_q, slot_q, trig_q;

  wire ackable   = ack_req && (frame_type == 3'd1 || frame_type == 3'd3);
  wire sym_last  = us_tick && (tick_cnt == TW'(TICKS_PER_SYM - 1));
  wire [SW-1:0] target_m1 = fast_q ? SW'(FAST_SYMS - 1) : SW'(SLOW_SYMS - 1);
  wire timer_fire = !slot_q && sym_last && (sym_cnt == target_m1);
  wire trig_rise  = slot_trig && !trig_q;
  wire go         = (st == ST_WAIT) && (slot_q ? trig_rise : timer_fire);

  assign state_o = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_LISTEN;
      tick_cnt   <= '0;
      sym_cnt    <= '0;
      fast_q     <= 1'b0;
      slot_q     <= 1'b0;
      trig_q     <= 1'b0;
      rx_end_irq <= 1'b0;
      tx_start   <= 1'b0;
      tx_end_irq <= 1'b0;
    end else begin
      rx_end_irq <= 1'b0;
      tx_start   <= 1'b0;
      tx_end_irq <= 1'b0;
      trig_q     <= slot_trig;
      case (st)
        ST_LISTEN: if (sfd_det) st <= ST_BUSY;
        ST_BUSY: if (frame_end) begin
          rx_end_irq <= 1'b1;
          tick_cnt   <= '0;
          sym_cnt    <= '0;
          fast_q     <= fast_ack;
          slot_q     <= slotted_en;
          st         <= ackable ? ST_WAIT : ST_LISTEN;
        end
        ST_WAIT: begin
          if (us_tick) begin
            if (sym_last) begin
              tick_cnt <= '0;
              sym_cnt  <= sym_cnt + 1'b1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          if (go) begin
            tx_start <= 1'b1;
            st       <= ST_TX;
          end
        end
        ST_TX: if (tx_done) begin
          tx_end_irq <= 1'b1;
          st         <= ST_LISTEN;
        end
        default: st <= ST_LISTEN;
      endcase
    end
  end

  p_busy_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LISTEN && sfd_det) |=> (state_o == 2'd1));
  p_rxend_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rx_end_irq |=> !rx_end_irq);
  p_txstart_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);
  p_txstart_state_r7: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (state_o == 2'd3));
  p_slot_no_timer_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && slot_q && !(slot_trig && !trig_q)) |=> (state_o == 2'd2));
  p_txend_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TX && tx_done) |=> (tx_end_irq && state_o == 2'd0));
  p_sfd_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && sfd_det && !go) |=> (state_o == 2'd2));
endmodule

// File: tb/tb_ack_turnaround_seq.sv
`timescale 1ns/1ps
module tb_ack_turnaround_seq;
  logic clk = 0, rst = 1;
  logic us_tick = 0, sfd_det = 0, frame_end = 0, ack_req = 0;
  logic fast_ack = 0, slotted_en = 0, slot_trig = 0, tx_done = 0;
  logic [2:0] frame_type = 0;
  logic [1:0] state_o;
  logic rx_end_irq, tx_start, tx_end_irq;

  int n_cmp = 0, n_bad = 0;
  int exp_kind[$];
  int exp_val[$];
  int tick_div = 1, tick_ph = 0, nticks = 0;

  ack_turnaround_seq dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    us_tick = (tick_ph == 0);
  end

  always @(posedge clk) begin
    if (frame_end) nticks = 0;
    else if (us_tick) nticks = nticks + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pop expected events as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_end_irq) pop_cmp(1, 0, "R3");
      if (tx_start)   pop_cmp(2, nticks, "R5/R6/R8");
      if (tx_end_irq) pop_cmp(3, 0, "R10");
    end
  end

  task automatic pop_cmp(input int kind, input int val, input string req);
    int k, v;
    if (exp_kind.size() == 0) begin
      chk(0, req, kind, 0);
      return;
    end
    k = exp_kind.pop_front();
    v = exp_val.pop_front();
    chk(k == kind, req, kind, k);
    if (k == kind && v >= 0) chk(v == val, req, val, v);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one complete frame transaction
  task automatic frame(input logic [2:0] ft, input bit req, input bit fast, input bit slot,
                       input bit early_trig);
    bit ackable;
    ackable = req && (ft == 3'd1 || ft == 3'd3);
    sfd_det = 1;
    cyc(1);
    sfd_det = 0;
    chk(state_o == 2'd1, "R2", state_o, 1);
    cyc(3);
    if (slot) begin
      slot_trig = 1;
      cyc(1);
      slot_trig = 0;
      chk(state_o == 2'd1, "R9", state_o, 1);
      cyc(1);
    end
    frame_type = ft; ack_req = req; fast_ack = fast; slotted_en = slot;
    frame_end = 1;
    if (early_trig) slot_trig = 1;
    exp_kind.push_back(1); exp_val.push_back(0);
    if (ackable) begin
      exp_kind.push_back(2);
      exp_val.push_back(slot ? -1 : 16 * (fast ? 2 : 12));
    end
    cyc(1);
    frame_end = 0; fast_ack = 0; slotted_en = 0;
    chk(state_o == (ackable ? 2'd2 : 2'd0), "R4", state_o, ackable ? 2 : 0);
    if (!ackable) begin
      cyc(2);
      return;
    end
    if (slot) begin
      cyc(5);
      sfd_det = 1;
      cyc(1);
      sfd_det = 0;
      chk(state_o == 2'd2, "R11", state_o, 2);
      cyc(250 * tick_div);
      chk(state_o == 2'd2, early_trig ? "R9" : "R8", state_o, 2);
      slot_trig = 0;
      cyc(2);
      slot_trig = 1;
      cyc(1);
      slot_trig = 0;
      chk(tx_start == 1'b1, "R8", tx_start, 1);
    end else begin
      for (int i = 0; i < 5000 && state_o != 2'd3; i++) cyc(1);
    end
    chk(state_o == 2'd3, "R7", state_o, 3);
    cyc(1);
    chk(tx_start == 1'b0, "R7", tx_start, 0);
    sfd_det = 1;
    cyc(2);
    sfd_det = 0;
    chk(state_o == 2'd3, "R11", state_o, 3);
    tx_done = 1;
    exp_kind.push_back(3); exp_val.push_back(0);
    cyc(1);
    tx_done = 0;
    chk(state_o == 2'd0, "R10", state_o, 0);
    cyc(1);
    chk(tx_end_irq == 1'b0, "R10", tx_end_irq, 0);
  endtask

  initial begin
    cyc(3);
    chk(state_o == 2'd0 && !rx_end_irq && !tx_start && !tx_end_irq, "R1", state_o, 0);
    rst = 0;
    cyc(2);
    chk(state_o == 2'd0, "R1", state_o, 0);
    frame(3'd1, 1, 0, 0, 0);   // data frame, slow turnaround
    frame(3'd3, 1, 1, 0, 0);   // command frame, fast turnaround
    frame(3'd0, 1, 0, 0, 0);   // beacon type: no ACK
    frame(3'd1, 0, 0, 0, 0);   // no ACK request
    tick_div = 3;
    frame(3'd1, 1, 0, 0, 0);   // sparse tick, slow
    frame(3'd1, 1, 1, 0, 0);   // sparse tick, fast
    tick_div = 1;
    frame(3'd1, 1, 0, 1, 0);   // slotted
    frame(3'd3, 1, 1, 1, 1);   // slotted, trigger in the frame-end cycle
    cyc(5);
    chk(exp_kind.size() == 0, "R3/R10", exp_kind.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule